// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block paces a controller-side I2C bus from a fixed 24 MHz clock. The transfer engine next to it hands over one bus action at a time (START, one data bit, or STOP). The generator then drives SCL low or releases it for register-programmed numbers of cycles. It answers with single-cycle strobes that tell the engine when to change SDA and when to capture it. Three 32-bit timing words, computed by software, hold every duration. They are read straight from their register inputs. Software is expected to change them only while the bus is idle.

Each low phase and each high phase carries a fixed hidden overhead on top of its programmed count. The high phase counter waits until SCL is actually seen high, so a target that stretches the clock delays the whole high phase. After a STOP, the block refuses a new START until the programmed bus-free gap has passed.

Commands use a valid/ready handshake. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The engine must hold `cmd_valid` and `cmd_op` stable until that happens. `cmd_ready` is high while SCL is parked low between actions, and in idle once the bus-free gap has expired. It is low for the whole of any phase in progress.

Top module: `scl_timing_gen`

## Requirements
- R1: Right after reset, SCL is released (`scl_low`=0), `cmd_ready` is 1, and all five strobes are 0.
- R2: Field layout of the timing words:
  - `hi_word[31:16]` is the high count and `hi_word[15:0]` is the receive sample offset.
  - `lo_word[31:16]` is the low count and `lo_word[15:0]` is the transmit launch offset.
  - `gap_word[31:16]` is the bus-free count and `gap_word[15:0]` is the START lead-in count.
- R3: A command taken while parked starts a low phase, with the accept cycle as low index 0. SCL is driven low for exactly low count + 2 cycles. `launch_stb` pulses once, at low index equal to the launch offset.
- R4: For a data bit (`cmd_op`=1), SCL is then released for exactly high count + 7 cycles.
  - `sample_stb` pulses at high index equal to the sample offset. High index 0 is the first cycle SCL is seen high.
  - `done_stb` pulses on the last high cycle.
  - SCL is then driven low again and `cmd_ready` returns the next cycle.
- R5: The high phase does not start counting while `scl_in` is held low by a target. A hold of K cycles delays the sample point and the end of the phase by K cycles. SCL still stays high for high count + 7 cycles.
- R6: A START (`cmd_op`=0) taken in idle gives `start_stb` on the next cycle. SCL stays released for lead-in + 1 cycles, counting from that strobe cycle. SCL is then driven low and the block is ready for the next command.
- R7: A START taken while parked (repeated START) runs a full low phase and a full high phase with no `sample_stb` or `done_stb`. It then gives `start_stb` and the lead-in of R6.
- R8: A STOP (`cmd_op`=2) taken while parked runs a full low phase and a full high phase. `stop_stb` pulses on the last high cycle, and SCL then stays released in idle.
- R9: After `stop_stb`, `cmd_ready` stays low for exactly the bus-free count of cycles. It rises bus-free + 1 cycles after the strobe. `start_stb` can come no earlier than bus-free + 2 cycles after `stop_stb`.
- R10: A data bit or STOP command taken in idle is dropped. SCL stays released, no strobe fires, and `cmd_ready` is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_word | input | 32 | High count and receive sample offset |
| lo_word | input | 32 | Low count and transmit launch offset |
| gap_word | input | 32 | Bus-free count and START lead-in count |
| cmd_valid | input | 1 | Engine offers a bus action |
| cmd_ready | output | 1 | Generator takes the offered action this cycle |
| cmd_op | input | 2 | 0 START, 1 data bit, 2 STOP (3 acts as a data bit) |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_low | output | 1 | 1 drives SCL low, 0 releases it |
| launch_stb | output | 1 | Engine may change SDA now |
| sample_stb | output | 1 | Engine captures SDA now |
| start_stb | output | 1 | Engine pulls SDA low to form a START |
| stop_stb | output | 1 | Engine releases SDA to form a STOP |
| done_stb | output | 1 | Last cycle of a data bit's high phase |

## Verification
The assertions check five properties on every cycle:
- the sample strobe fires only while SCL reads high;
- the launch strobe fires only while SCL is driven low;
- a START strobe never coincides with SCL driven low;
- SCL is released right after a STOP strobe;
- no START strobe comes within the bus-free distance of the last STOP.

Only the bench scenarios can show the rest: the exact phase lengths with their hidden overheads, the strobe positions for each offset, the shift caused by a stretching target, and that commands taken in idle leave the bus untouched.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BIT   = 2'd1,
    OP_STOP  = 2'd2,
    OP_RSVD  = 2'd3
  } tg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PARK,
    ST_LOW,
    ST_HIGH
  } tg_state_e;
endpackage

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  input  logic [CW-1:0] len,
  input  logic [CW-1:0] mark,
  output logic          at_mark,
  output logic          at_end,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  assign at_mark = (cnt == mark);
  assign at_end  = (cnt == len - 1'b1);
  assign busy    = (cnt != '0);
endmodule

// File: rtl/scl_gap_timer.sv
module scl_gap_timer #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] val,
  output logic          expired
);
  logic [GW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (load)            remain <= val;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // Once counting, the remaining gap only shrinks until a new load.
  assert_gap_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (remain <= $past(remain)));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int FIELD_W  = 16,
  parameter int LOW_PAD  = 2,
  parameter int HIGH_PAD = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*FIELD_W-1:0] hi_word,
  input  logic [2*FIELD_W-1:0] lo_word,
  input  logic [2*FIELD_W-1:0] gap_word,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic                 scl_in,
  output logic                 scl_low,
  output logic                 launch_stb,
  output logic                 sample_stb,
  output logic                 start_stb,
  output logic                 stop_stb,
  output logic                 done_stb
);
  import scl_tg_pkg::*;

  localparam int CW = FIELD_W + 1;

  // Field split of the three timing words (R2)
  logic [FIELD_W-1:0] f_high, f_rx, f_low, f_tx, f_free, f_lead;
  assign f_high = hi_word[2*FIELD_W-1:FIELD_W];
  assign f_rx   = hi_word[FIELD_W-1:0];
  assign f_low  = lo_word[2*FIELD_W-1:FIELD_W];
  assign f_tx   = lo_word[FIELD_W-1:0];
  assign f_free = gap_word[2*FIELD_W-1:FIELD_W];
  assign f_lead = gap_word[FIELD_W-1:0];

  tg_state_e st;
  tg_op_e    op_q;
  logic      fire, gap_ok, hi_active;
  logic      ph_adv, ph_clr, ph_mark, ph_end, ph_busy;
  logic [CW-1:0] ph_len, ph_mark_v;
  logic      op_is_bit;

  assign cmd_ready = (st == ST_PARK) || ((st == ST_IDLE) && gap_ok);
  assign fire      = cmd_valid && cmd_ready;
  assign op_is_bit = (op_q == OP_BIT) || (op_q == OP_RSVD);

  // Phase length and strobe point for the phase in progress
  always_comb begin
    unique case (st)
      ST_HIGH: begin
        ph_len    = {1'b0, f_high} + CW'(HIGH_PAD);
        ph_mark_v = {1'b0, f_rx};
      end
      ST_LEAD: begin
        ph_len    = {1'b0, f_lead} + CW'(1);
        ph_mark_v = '0;
      end
      default: begin
        ph_len    = {1'b0, f_low} + CW'(LOW_PAD);
        ph_mark_v = {1'b0, f_tx};
      end
    endcase
  end

  // High phase counts only once SCL is seen high (R5)
  assign hi_active = (st == ST_HIGH) && (scl_in || ph_busy);
  assign ph_adv = ((st == ST_PARK) && fire) || (st == ST_LOW) ||
                  hi_active || (st == ST_LEAD);
  assign ph_clr = ph_end && ((st == ST_LOW) || hi_active || (st == ST_LEAD));

  scl_phase_ctr #(.CW(CW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (ph_adv),
    .clr     (ph_clr),
    .len     (ph_len),
    .mark    (ph_mark_v),
    .at_mark (ph_mark),
    .at_end  (ph_end),
    .busy    (ph_busy)
  );

  scl_gap_timer #(.GW(FIELD_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (stop_stb),
    .val     (f_free),
    .expired (gap_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      op_q <= OP_BIT;
    end else begin
      unique case (st)
        ST_IDLE: if (fire && tg_op_e'(cmd_op) == OP_START) st <= ST_LEAD;
        ST_LEAD: if (ph_end) st <= ST_PARK;
        ST_PARK: if (fire) begin
          st   <= ST_LOW;
          op_q <= tg_op_e'(cmd_op);
        end
        ST_LOW:  if (ph_end) st <= ST_HIGH;
        ST_HIGH: if (hi_active && ph_end) begin
          if (op_q == OP_START)     st <= ST_LEAD;
          else if (op_q == OP_STOP) st <= ST_IDLE;
          else                      st <= ST_PARK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign scl_low    = (st == ST_PARK) || (st == ST_LOW);
  assign launch_stb = ph_mark && (((st == ST_PARK) && fire) || (st == ST_LOW));
  assign sample_stb = hi_active && ph_mark && op_is_bit;
  assign done_stb   = hi_active && ph_end && op_is_bit;
  assign stop_stb   = hi_active && ph_end && (op_q == OP_STOP);
  assign start_stb  = (st == ST_LEAD) && ph_mark;

  // Checking aids: distance from the most recent STOP strobe
  logic          stop_seen;
  logic [CW-1:0] since_stop;
  logic [FIELD_W-1:0] free_at_stop;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_seen    <= 1'b0;
      since_stop   <= '0;
      free_at_stop <= '0;
    end else if (stop_stb) begin
      stop_seen    <= 1'b1;
      since_stop   <= '0;
      free_at_stop <= f_free;
    end else if (since_stop != '1) begin
      since_stop <= since_stop + 1'b1;
    end
  end

  assert_sample_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> scl_in);
  assert_launch_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> scl_low);
  assert_start_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> !scl_low);
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !scl_low);
  assert_bus_free_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && stop_seen) |-> (since_stop > {1'b0, free_at_stop}));
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hi_word = '0, lo_word = '0, gap_word = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        tgt_hold = 1'b0;
  logic        cmd_ready, scl_low, launch_stb, sample_stb, start_stb, stop_stb, done_stb;
  logic        scl_bus;

  assign scl_bus = !scl_low && !tgt_hold;

  always #2 clk = ~clk;

  scl_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .hi_word(hi_word), .lo_word(lo_word), .gap_word(gap_word),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .scl_in(scl_bus),
    .scl_low(scl_low), .launch_stb(launch_stb), .sample_stb(sample_stb),
    .start_stb(start_stb), .stop_stb(stop_stb), .done_stb(done_stb)
  );

  int total = 0, bad = 0;
  int r_launch, r_sample, r_start, r_stop, r_done, r_low, r_hin, r_ready;

  // hi, rx, lo, tx, expected low length, expected high length
  localparam int VEC [4][6] = '{
    '{3, 1, 4, 2, 6, 10},
    '{1, 0, 1, 0, 3, 8},
    '{5, 11, 6, 7, 8, 12},
    '{40, 17, 47, 18, 49, 47}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int hold_from, input int hold_len);
    r_launch = -1; r_sample = -1; r_start = -1; r_stop = -1; r_done = -1;
    r_low = 0; r_hin = 0; r_ready = -1;
    @(negedge clk);
    cmd_op = op;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      tgt_hold = (i >= hold_from) && (i < hold_from + hold_len);
      #1;
      if (i > 0 && cmd_ready) begin
        r_ready = i;
        break;
      end
      if (launch_stb && r_launch < 0) r_launch = i;
      if (sample_stb && r_sample < 0) r_sample = i;
      if (start_stb && r_start < 0)   r_start = i;
      if (stop_stb && r_stop < 0)     r_stop = i;
      if (done_stb && r_done < 0)     r_done = i;
      if (scl_low) r_low++;
      if (scl_bus) r_hin++;
      @(posedge clk);
      #1 cmd_valid = 1'b0;
      @(negedge clk);
    end
    tgt_hold = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, rx, lo, tx, gap, lead;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 scl_low after reset", int'(scl_low), 0);
    chk("R1 ready during reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 scl_low after release", int'(scl_low), 0);
    chk("R1 ready after release", int'(cmd_ready), 1);
    chk("R1 strobes quiet", int'({launch_stb, sample_stb, start_stb, stop_stb, done_stb}), 0);

    // Table walk: START, BIT, STOP per timing set (R2 field layout used throughout)
    for (int v = 0; v < 4; v++) begin
      hi = VEC[v][0]; rx = VEC[v][1]; lo = VEC[v][2]; tx = VEC[v][3];
      gap = 3 + v; lead = 2 + v;
      hi_word  = {hi[15:0], rx[15:0]};
      lo_word  = {lo[15:0], tx[15:0]};
      gap_word = {gap[15:0], lead[15:0]};

      run_op(2'd0, 9999, 0);
      chk("R6 start strobe index", r_start, 1);
      chk("R6 released span", r_hin, lead + 2);
      chk("R6 ready index", r_ready, lead + 2);

      run_op(2'd1, 9999, 0);
      chk("R3 low length", r_low, VEC[v][4]);
      chk("R3 launch index", r_launch, tx);
      chk("R2 R4 high length", r_hin, VEC[v][5]);
      chk("R4 sample index", r_sample, lo + 2 + rx);
      chk("R4 done index", r_done, lo + hi + 8);
      chk("R4 ready index", r_ready, lo + hi + 9);

      run_op(2'd2, 9999, 0);
      chk("R8 stop index", r_stop, lo + hi + 8);
      chk("R8 no sample on stop", r_sample, -1);
      chk("R8 released incl gap", r_hin, hi + 7 + gap);
      chk("R9 ready after gap", r_ready, lo + hi + 9 + gap);
    end

    // Directed set for corner cases
    hi = 3; rx = 1; lo = 4; tx = 2; gap = 5; lead = 3;
    hi_word  = {hi[15:0], rx[15:0]};
    lo_word  = {lo[15:0], tx[15:0]};
    gap_word = {gap[15:0], lead[15:0]};

    // R10: data bit and STOP in idle are dropped
    run_op(2'd1, 9999, 0);
    chk("R10 bit in idle ready", r_ready, 1);
    chk("R10 bit in idle low", r_low, 0);
    chk("R10 bit in idle strobes", r_launch + r_sample + r_done + r_start + r_stop, -5);
    run_op(2'd2, 9999, 0);
    chk("R10 stop in idle ready", r_ready, 1);
    chk("R10 stop in idle low", r_low, 0);
    chk("R10 stop in idle strobes", r_launch + r_stop + r_start, -3);

    // R7: repeated START
    run_op(2'd0, 9999, 0);
    run_op(2'd0, 9999, 0);
    chk("R7 repeated start index", r_start, lo + hi + 9);
    chk("R7 no sample", r_sample, -1);
    chk("R7 no done", r_done, -1);
    chk("R7 low length", r_low, lo + 2);
    chk("R7 ready index", r_ready, lo + hi + lead + 10);

    // R5: target holds SCL low for 5 cycles after release
    run_op(2'd1, lo + 2, 5);
    chk("R5 high length under stretch", r_hin, hi + 7);
    chk("R5 sample shifted", r_sample, lo + 2 + 5 + rx);
    chk("R5 done shifted", r_done, lo + hi + 13);
    chk("R5 ready shifted", r_ready, lo + hi + 14);

    // R9: STOP then START back to back
    run_op(2'd2, 9999, 0);
    chk("R9 ready after gap directed", r_ready, lo + hi + 9 + gap);
    run_op(2'd0, 9999, 0);
    chk("R9 start after gap", r_start, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule